// File: doc/BRIEF.md
# Ethernet receive frame status classifier

This block sits beside a MAC receive path and watches each incoming frame as a stream of bytes. The stream begins at the first destination-address byte, with preamble and start delimiter already stripped, and runs through the four FCS bytes. A start strobe opens a frame. Each data byte arrives with a valid flag. An end strobe in its own cycle closes the frame and carries the count of trailing dribble bits together with the address-filter result.

One cycle after the end strobe the block presents a single 32-bit status word with a one-cycle valid pulse. The word then holds until the next frame ends. The word classifies the frame as broadcast, multicast, VLAN-tagged, PAUSE control or type-field frame. It also flags the length, CRC, alignment, FIFO-overflow and FIFO-parity errors, and it reports a Good bit and a halted bit for the receive path. Software or a DMA engine stores the word alongside the frame data.

Top module: `rx_frame_status`

## Requirements
- R1: `stat_vld` pulses high for exactly one cycle, in the cycle after `eof` is sampled. `stat_word` changes only at that point and holds its value otherwise. After reset the word reads 0x3E008000. Bits 31:30, bit 16 and bits 7:0 are always zero.
- R2: Bit 18 (broadcast) is set when all of the first six bytes are 0xFF. Bit 17 (multicast) is set when bit 0 of byte 0 is 1 and the frame is not broadcast.
- R3: Bit 19 (tagged) is set when bytes 12 and 13 are 0x81 and 0x00. In a tagged frame the length/type field is bytes 16–17 and the control opcode is bytes 18–19. Otherwise they are bytes 12–13 and 14–15.
- R4: Bit 20 (pause) is set when the length/type field is 0x8808 and the opcode that follows it is 0x0001.
- R5: Bit 12 (type packet) is set when the length/type field is greater than 1500. No length consistency check is made.
- R6: Bit 11 (long) is set when the byte count, from destination address through FCS, exceeds 1518 for an untagged frame or 1522 for a tagged frame. It is never set while `long_en` is 1.
- R7: Bit 9 (CRC) is set when the CRC-32 over all bytes, including the FCS, does not leave the residue. It is also set when `rx_err` was high in any cycle from the one after `sof` up to and including `eof`.
- R8: Bit 8 (alignment) is set only when `dribble_bits` is non-zero at `eof` and bit 9 is also set.
- R9: Bit 10 (overflow) and bit 13 (parity) are set when `fifo_ovf` or `par_err`, respectively, pulsed in any cycle from the one after `sof` up to and including `eof`.
- R10: Bit 14 (Good) is set exactly when bits 13, 11, 10, 9 and 8 are all clear.
- R11: Bits 29:25 carry `match_idx` when `match_hit` is 1 at `eof`, and 0x1F otherwise. Bits 24:21 carry `match_stat` as sampled at `eof`.
- R12: Bit 15 (halted) resets to 1. It becomes 1 whenever `rx_en` is 0 or `halt_imm` is 1. It clears only at a `sof` with `rx_en` at 1 and `halt_imm` at 0. The word reports its value at `eof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Start-of-frame strobe, a cycle of its own before the first byte |
| byte_vld | input | 1 | `byte_dat` carries a frame byte |
| byte_dat | input | 8 | Received byte |
| eof | input | 1 | End-of-frame strobe, a cycle of its own after the last byte |
| dribble_bits | input | 3 | Trailing bits beyond a whole byte, valid with `eof` |
| rx_err | input | 1 | PHY receive-error flag |
| fifo_ovf | input | 1 | Receive FIFO lost a byte |
| par_err | input | 1 | Receive FIFO parity error |
| match_hit | input | 1 | Address filter matched, valid with `eof` |
| match_idx | input | 5 | Matching filter entry, valid with `eof` |
| match_stat | input | 4 | Filter status code, valid with `eof` |
| long_en | input | 1 | Allow long frames without error |
| rx_en | input | 1 | Receive enable |
| halt_imm | input | 1 | Immediate halt request |
| stat_vld | output | 1 | Status word strobe |
| stat_word | output | 32 | Frame status word |

## Verification
The bench sweeps destination kinds against tag presence and five length/type values. The sweep includes an almost-broadcast address, which catches a broadcast test that checks only one byte or lets multicast overlap with broadcast. Length is driven exactly at the limits and one byte past them, with and without a tag and with `long_en` set. An off-by-one comparison, or a limit that ignores the tag, would flag or miss exactly one of those frames. Dribble bits are sent with a good FCS and with a bad one, and rx_err is sent with a good FCS. A design that drew alignment from dribble bits alone, or that ignored rx_err for the CRC bit, would set a wrong bit and clear Good. Halt, disable and the filter miss index are also checked, along with pulse timing against a status word that must hold between frames.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    localparam int WORD_W = 32;
    localparam int IDX_W  = 5;
    localparam int MST_W  = 4;

    localparam logic [31:0] CRC_POLY_R  = 32'hEDB88320;
    localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;

    localparam logic [15:0] TAG_TPID   = 16'h8100;
    localparam logic [15:0] CTRL_TYPE  = 16'h8808;
    localparam logic [15:0] PAUSE_OP   = 16'h0001;

    localparam int B_IDX_LO = 25;
    localparam int B_MST_LO = 21;
    localparam int B_PAUSE  = 20;
    localparam int B_VLAN   = 19;
    localparam int B_BC     = 18;
    localparam int B_MC     = 17;
    localparam int B_HALT   = 15;
    localparam int B_GOOD   = 14;
    localparam int B_PAR    = 13;
    localparam int B_TYPE   = 12;
    localparam int B_LONG   = 11;
    localparam int B_OVF    = 10;
    localparam int B_CRC    = 9;
    localparam int B_ALIGN  = 8;

    typedef struct packed {
        logic        bcast;
        logic        mcast;
        logic        vlan;
        logic [15:0] type_f;
        logic [15:0] op_f;
    } hdr_t;

    typedef struct packed {
        logic rxer;
        logic ovf;
        logic par;
    } sticky_t;

    function automatic logic [WORD_W-1:0] reset_word();
        logic [WORD_W-1:0] w;
        w = '0;
        w[B_IDX_LO +: IDX_W] = '1;
        w[B_HALT] = 1'b1;
        return w;
    endfunction
endpackage

// File: rtl/rxs_crc32.sv
module rxs_crc32
    import rxs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sof,
    input  logic        byte_vld,
    input  logic [7:0]  byte_dat,
    output logic [31:0] crc_q
);
    logic [31:0] crc_d;

    always_comb begin
        logic [31:0] c;
        c = crc_q ^ {24'b0, byte_dat};
        for (int k = 0; k < 8; k++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_R) : (c >> 1);
        end
        crc_d = crc_q;
        if (sof)
            crc_d = '1;
        else if (byte_vld)
            crc_d = c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= '1;
        else        crc_q <= crc_d;
    end

    // R7
    crc_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> (crc_q == 32'hFFFFFFFF));
endmodule

// File: rtl/rxs_err_track.sv
module rxs_err_track
    import rxs_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             byte_vld,
    input  logic             rx_err,
    input  logic             fifo_ovf,
    input  logic             par_err,
    output logic [CNT_W-1:0] cnt_q,
    output sticky_t          sticky_q
);
    logic [CNT_W-1:0] cnt_d;
    sticky_t          sticky_d;

    always_comb begin
        cnt_d    = cnt_q;
        sticky_d = sticky_q;
        if (sof) begin
            cnt_d    = '0;
            sticky_d = '0;
        end else begin
            if (byte_vld && (cnt_q != '1))
                cnt_d = cnt_q + 1'b1;
            sticky_d.rxer = sticky_q.rxer | rx_err;
            sticky_d.ovf  = sticky_q.ovf  | fifo_ovf;
            sticky_d.par  = sticky_q.par  | par_err;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            sticky_q <= '0;
        end else begin
            cnt_q    <= cnt_d;
            sticky_q <= sticky_d;
        end
    end

    // R6
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> (cnt_q == '0));
    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sof && fifo_ovf) |=> sticky_q.ovf);
endmodule

// File: rtl/rxs_hdr_parse.sv
module rxs_hdr_parse
    import rxs_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             byte_vld,
    input  logic [7:0]       byte_dat,
    input  logic [CNT_W-1:0] idx,
    output hdr_t             hdr_q
);
    localparam int DA_LEN = 6;
    localparam int TOFF   = 12;
    localparam int TAGLEN = 4;

    hdr_t hdr_d;

    always_comb begin
        hdr_d = hdr_q;
        if (sof) begin
            hdr_d       = '0;
            hdr_d.bcast = 1'b1;
        end else if (byte_vld) begin
            if (idx < CNT_W'(DA_LEN))
                hdr_d.bcast = hdr_q.bcast & (byte_dat == 8'hFF);
            if (idx == CNT_W'(0))
                hdr_d.mcast = byte_dat[0];
            if (idx == CNT_W'(TOFF))
                hdr_d.type_f[15:8] = byte_dat;
            if (idx == CNT_W'(TOFF + 1)) begin
                hdr_d.type_f[7:0] = byte_dat;
                hdr_d.vlan = ({hdr_q.type_f[15:8], byte_dat} == TAG_TPID);
            end
            if (idx == CNT_W'(TOFF + 2))
                hdr_d.op_f[15:8] = byte_dat;
            if (idx == CNT_W'(TOFF + 3))
                hdr_d.op_f[7:0] = byte_dat;
            if (hdr_q.vlan) begin
                if (idx == CNT_W'(TOFF + TAGLEN))
                    hdr_d.type_f[15:8] = byte_dat;
                if (idx == CNT_W'(TOFF + TAGLEN + 1))
                    hdr_d.type_f[7:0] = byte_dat;
                if (idx == CNT_W'(TOFF + TAGLEN + 2))
                    hdr_d.op_f[15:8] = byte_dat;
                if (idx == CNT_W'(TOFF + TAGLEN + 3))
                    hdr_d.op_f[7:0] = byte_dat;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_q       <= '0;
            hdr_q.bcast <= 1'b1;
        end else begin
            hdr_q <= hdr_d;
        end
    end

    // R2
    bcast_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sof && byte_vld && (idx < CNT_W'(DA_LEN)) && (byte_dat != 8'hFF)) |=> !hdr_q.bcast);
endmodule

// File: rtl/rx_frame_status.sv
module rx_frame_status
    import rxs_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int MAX_LEN    = 1518,
    parameter int TAG_EXTRA  = 4,
    parameter int TYPE_LIM   = 1500,
    parameter int DRIB_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof,
    input  logic              byte_vld,
    input  logic [7:0]        byte_dat,
    input  logic              eof,
    input  logic [DRIB_W-1:0] dribble_bits,
    input  logic              rx_err,
    input  logic              fifo_ovf,
    input  logic              par_err,
    input  logic              match_hit,
    input  logic [4:0]        match_idx,
    input  logic [3:0]        match_stat,
    input  logic              long_en,
    input  logic              rx_en,
    input  logic              halt_imm,
    output logic              stat_vld,
    output logic [31:0]       stat_word
);
    localparam logic [CNT_W-1:0] LIM_PLAIN = CNT_W'(MAX_LEN);
    localparam logic [CNT_W-1:0] LIM_TAG   = CNT_W'(MAX_LEN + TAG_EXTRA);

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] word;
        logic              halted;
    } top_t;

    top_t             st_d, st_q;
    logic [31:0]      crc_q;
    logic [CNT_W-1:0] cnt_q;
    sticky_t          sticky_q;
    hdr_t             hdr_q;

    rxs_crc32 i_crc (
        .clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld),
        .byte_dat(byte_dat), .crc_q(crc_q)
    );

    rxs_err_track #(.CNT_W(CNT_W)) i_err (
        .clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld),
        .rx_err(rx_err), .fifo_ovf(fifo_ovf), .par_err(par_err),
        .cnt_q(cnt_q), .sticky_q(sticky_q)
    );

    rxs_hdr_parse #(.CNT_W(CNT_W)) i_hdr (
        .clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld),
        .byte_dat(byte_dat), .idx(cnt_q), .hdr_q(hdr_q)
    );

    always_comb begin
        logic crc_bad, align, ovf, par, long_f, halt_now;
        logic [WORD_W-1:0] w;

        crc_bad  = (crc_q != CRC_RESIDUE) | sticky_q.rxer | rx_err;
        align    = (dribble_bits != '0) & crc_bad;
        ovf      = sticky_q.ovf | fifo_ovf;
        par      = sticky_q.par | par_err;
        long_f   = !long_en && (cnt_q > (hdr_q.vlan ? LIM_TAG : LIM_PLAIN));
        halt_now = !rx_en || halt_imm;

        w = '0;
        w[B_IDX_LO +: IDX_W] = match_hit ? match_idx : 5'h1F;
        w[B_MST_LO +: MST_W] = match_stat;
        w[B_PAUSE] = (hdr_q.type_f == CTRL_TYPE) && (hdr_q.op_f == PAUSE_OP);
        w[B_VLAN]  = hdr_q.vlan;
        w[B_BC]    = hdr_q.bcast;
        w[B_MC]    = hdr_q.mcast && !hdr_q.bcast;
        w[B_HALT]  = st_q.halted || halt_now;
        w[B_PAR]   = par;
        w[B_TYPE]  = hdr_q.type_f > 16'(TYPE_LIM);
        w[B_LONG]  = long_f;
        w[B_OVF]   = ovf;
        w[B_CRC]   = crc_bad;
        w[B_ALIGN] = align;
        w[B_GOOD]  = !(par || long_f || ovf || crc_bad || align);

        st_d     = st_q;
        st_d.vld = eof;
        if (eof)
            st_d.word = w;
        if (halt_now)
            st_d.halted = 1'b1;
        else if (sof)
            st_d.halted = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.vld    <= 1'b0;
            st_q.word   <= reset_word();
            st_q.halted <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_vld  = st_q.vld;
    assign stat_word = st_q.word;

    // R1
    vld_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld |-> $past(eof));
    // R1
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(eof) |-> $stable(stat_word));
    // R2
    bc_mc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld |-> !(stat_word[B_BC] && stat_word[B_MC]));
    // R8
    align_needs_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_vld && stat_word[B_ALIGN]) |-> stat_word[B_CRC]);
    // R10
    good_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_vld && stat_word[B_GOOD]) |->
            !(stat_word[B_PAR] | stat_word[B_LONG] | stat_word[B_OVF] | stat_word[B_CRC]));
    // R11
    miss_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_vld && $past(!match_hit)) |-> (stat_word[29:25] == 5'h1F));
    // R12
    halt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en || halt_imm) |=> st_q.halted);
endmodule

// File: tb/test_rx_frame_status.sv
module test_rx_frame_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof = 0, byte_vld = 0, eof = 0;
    logic [7:0]  byte_dat = '0;
    logic [2:0]  dribble_bits = '0;
    logic        rx_err = 0, fifo_ovf = 0, par_err = 0, match_hit = 0;
    logic [4:0]  match_idx = '0;
    logic [3:0]  match_stat = '0;
    logic        long_en = 0, rx_en = 1, halt_imm = 0;
    logic        stat_vld;
    logic [31:0] stat_word;

    always #5 clk = ~clk;

    rx_frame_status i_rx_frame_status (
        .clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld), .byte_dat(byte_dat),
        .eof(eof), .dribble_bits(dribble_bits), .rx_err(rx_err), .fifo_ovf(fifo_ovf),
        .par_err(par_err), .match_hit(match_hit), .match_idx(match_idx),
        .match_stat(match_stat), .long_en(long_en), .rx_en(rx_en), .halt_imm(halt_imm),
        .stat_vld(stat_vld), .stat_word(stat_word)
    );

    int checks = 0;
    int fails  = 0;

    logic [7:0] fb [0:2047];
    int  flen;
    logic [31:0] exp_base;
    int  o_bad, o_rxe, o_ovf, o_par, o_halt, o_off, o_hit, o_idx, o_st;
    int  o_drib;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_opts();
        o_bad = 0; o_rxe = -1; o_ovf = -1; o_par = -1; o_halt = -1; o_off = -1;
        o_drib = 0; o_hit = 1; o_idx = 3; o_st = 2;
    endtask

    // dk: 0 broadcast, 1 multicast, 2 unicast, 3 all-ones except last byte
    task automatic build(input int len, input int dk, input bit vl,
                         input logic [15:0] ty, input logic [15:0] op);
        logic [31:0] c;
        int p;
        for (int i = 0; i < 6; i++) begin
            case (dk)
                0: fb[i] = 8'hFF;
                1: fb[i] = (i == 0) ? 8'h01 : 8'(8'h5E + i);
                2: fb[i] = (i == 0) ? 8'h02 : 8'(8'h11 * i);
                default: fb[i] = (i == 5) ? 8'hFE : 8'hFF;
            endcase
        end
        for (int i = 6; i < 12; i++) fb[i] = 8'(8'h10 + i);
        p = 12;
        if (vl) begin
            fb[12] = 8'h81; fb[13] = 8'h00; fb[14] = 8'h00; fb[15] = 8'h05; p = 16;
        end
        fb[p] = ty[15:8]; fb[p+1] = ty[7:0]; fb[p+2] = op[15:8]; fb[p+3] = op[7:0];
        for (int i = p + 4; i < len - 4; i++) fb[i] = 8'(i * 13);
        c = 32'hFFFFFFFF;
        for (int i = 0; i < len - 4; i++) begin
            c = c ^ {24'b0, fb[i]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        c = ~c;
        for (int i = 0; i < 4; i++) fb[len - 4 + i] = c[8*i +: 8];
        flen = len;
        exp_base = '0;
        exp_base[20] = (ty == 16'h8808) && (op == 16'h0001);        // R4
        exp_base[19] = vl;                                          // R3
        exp_base[18] = (dk == 0);                                   // R2
        exp_base[17] = (dk == 1) || (dk == 3);                      // R2
        exp_base[12] = (ty > 16'd1500);                             // R5
        exp_base[11] = !long_en && (len > (vl ? 1522 : 1518));      // R6
    endtask

    function automatic logic [31:0] expect_word();
        logic [31:0] w;
        logic crc_b;
        w = exp_base;
        crc_b = (o_bad != 0) || (o_rxe >= 0);
        w[29:25] = (o_hit != 0) ? 5'(o_idx) : 5'h1F;                // R11
        w[24:21] = 4'(o_st);
        w[15] = (o_halt >= 0) || (o_off >= 0);                      // R12
        w[13] = (o_par >= 0);                                       // R9
        w[10] = (o_ovf >= 0);                                       // R9
        w[9]  = crc_b;                                              // R7
        w[8]  = crc_b && (o_drib != 0);                             // R8
        w[14] = !(w[13] | w[11] | w[10] | w[9] | w[8]);             // R10
        return w;
    endfunction

    task automatic send(input string tag);
        logic [31:0] ew, held;
        @(negedge clk); sof = 1;
        @(negedge clk); sof = 0;
        for (int i = 0; i < flen; i++) begin
            byte_vld = 1;
            byte_dat = (o_bad != 0 && i == flen - 1) ? (fb[i] ^ 8'h04) : fb[i];
            rx_err   = (i == o_rxe);
            fifo_ovf = (i == o_ovf);
            par_err  = (i == o_par);
            halt_imm = (i == o_halt);
            rx_en    = !(i == o_off);
            @(negedge clk);
        end
        byte_vld = 0; rx_err = 0; fifo_ovf = 0; par_err = 0; halt_imm = 0; rx_en = 1;
        chk({"R1 no strobe before eof ", tag}, {31'b0, stat_vld}, 32'd0);
        eof = 1; dribble_bits = 3'(o_drib);
        match_hit = (o_hit != 0); match_idx = 5'(o_idx); match_stat = 4'(o_st);
        @(negedge clk);
        eof = 0; dribble_bits = '0; match_hit = 0;
        ew = expect_word();
        chk({"R1 strobe ", tag}, {31'b0, stat_vld}, 32'd1);
        chk({"R2-R12 word ", tag}, stat_word, ew);
        held = stat_word;
        @(negedge clk);
        chk({"R1 single pulse ", tag}, {31'b0, stat_vld}, 32'd0);
        chk({"R1 word held ", tag}, stat_word, held);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] tys [0:4];
        logic [15:0] ops [0:4];
        tys[0] = 16'h002E; ops[0] = 16'h0001;
        tys[1] = 16'h05DC; ops[1] = 16'h0001;
        tys[2] = 16'h05DD; ops[2] = 16'h0001;
        tys[3] = 16'h8808; ops[3] = 16'h0001;
        tys[4] = 16'h8808; ops[4] = 16'h0002;
        clear_opts();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 R11 R12 reset word
        chk("R1 reset strobe", {31'b0, stat_vld}, 32'd0);
        chk("R12 reset word", stat_word, 32'h3E008000);

        // R2 R3 R4 R5 R11 sweep of destination kind, tag and type field
        for (int dk = 0; dk < 4; dk++)
            for (int vl = 0; vl < 2; vl++)
                for (int tk = 0; tk < 5; tk++) begin
                    clear_opts();
                    o_hit = tk % 2; o_idx = dk * 5 + tk; o_st = tk + dk;
                    build(64 + dk + tk, dk, vl[0], tys[tk], ops[tk]);
                    send("sweep");
                end

        // R6 length limits
        for (int vl = 0; vl < 2; vl++)
            for (int d = 0; d < 2; d++) begin
                clear_opts();
                build((vl != 0 ? 1522 : 1518) + d, 2, vl[0], 16'h0800, 16'h4500);
                send("R6 limit");
            end
        long_en = 1;
        for (int vl = 0; vl < 2; vl++) begin
            clear_opts();
            build((vl != 0 ? 1522 : 1518) + 1, 2, vl[0], 16'h0800, 16'h4500);
            send("R6 long_en");
        end
        long_en = 0;

        // R7 R8 CRC and alignment
        clear_opts(); o_bad = 1; build(80, 2, 0, 16'h0800, 16'h0000); send("R7 bad fcs");
        clear_opts(); o_rxe = 20; build(80, 2, 0, 16'h0800, 16'h0000); send("R7 rx_err");
        clear_opts(); o_drib = 3; build(80, 2, 0, 16'h0800, 16'h0000); send("R8 dribble good crc");
        clear_opts(); o_drib = 5; o_bad = 1; build(80, 2, 0, 16'h0800, 16'h0000); send("R8 dribble bad crc");
        clear_opts(); o_drib = 1; o_rxe = 70; build(80, 1, 0, 16'h0800, 16'h0000); send("R8 dribble rx_err");
        // R9 overflow, parity
        clear_opts(); o_ovf = 30; build(90, 0, 0, 16'h0800, 16'h0000); send("R9 overflow");
        clear_opts(); o_par = 40; build(90, 0, 1, 16'h0800, 16'h0000); send("R9 parity");
        // R11 miss
        clear_opts(); o_hit = 0; o_idx = 7; o_st = 9; build(70, 2, 0, 16'h0800, 16'h0000); send("R11 miss");
        // R12 halt and disable
        clear_opts(); o_halt = 10; build(70, 2, 0, 16'h0800, 16'h0000); send("R12 halt_imm");
        clear_opts(); o_off = 15; build(70, 2, 0, 16'h0800, 16'h0000); send("R12 rx_en low");
        clear_opts(); build(70, 2, 0, 16'h0800, 16'h0000); send("R12 cleared by sof");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule